// File: doc/BRIEF.md
# Register-Controlled Output Selector

The block drives a five-bit open-drain output port. Each cycle the port shows one of three values: the five data bits held in output register A, the five data bits held in output register B, or the live five-bit input port. The source is chosen by a two-bit select field stored in register A. An external pin pair can override that field in hardware, and an active-low enable pin forces every output to zero.

A small register bus reaches three locations. Registers A and B are read/write at addresses 0 and 1. Address 2 is a read-only copy of the input port. That copy is refreshed on the clock edge after each one-cycle start strobe from an upstream serial controller. A write-lock pin freezes both output registers. Reads are combinational on the address.

Top module: `reg_out_sel`

## Requirements
- R1: A bus write (req_i=1, we_i=1) to address 0 stores the byte in register A, and one to address 1 stores it in register B. A read of either address returns the full stored byte.
- R2: With hw_sel_i=0, bits 7:6 of register A pick the source. 00 selects register A's data, 01 selects register B's data, and 10 or 11 selects in_port_i.
- R3: A register's five output bits are {bit 5, bits 3:0}. Output bit 4 comes from register bit 5, and register bit 4 never reaches the outputs.
- R4: When out_en_i is 0, pad_val_o is 00000 regardless of every other input.
- R5: When hw_sel_i is 1, ab_sel_i=0 selects register A's data and ab_sel_i=1 selects register B's data, ignoring the stored select field. R4 still takes priority.
- R6: While wr_lock_i is 1, writes leave registers A and B unchanged.
- R7: After a start_i pulse sampled at clock edge k, the snapshot loads in_port_i as sampled at edge k+1. At all other times it holds its value.
- R8: A read of address 2 returns {000, snapshot}. Writes to address 2 change nothing.
- R9: A read of any address above 2 returns 8'h00, and writes to such addresses change nothing.
- R10: Reset sets both output registers to 8'h80 and clears the snapshot, so the outputs follow in_port_i.
- R11: pad_pull_low_o is the bitwise inverse of pad_val_o: a 1 pulls the pad low and a 0 releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| start_i | input | 1 | One-cycle start-condition strobe |
| in_port_i | input | 5 | Live input port |
| out_en_i | input | 1 | Active-low output force; 0 drives all outputs to zero |
| hw_sel_i | input | 1 | Hardware source select enable |
| ab_sel_i | input | 1 | Register choice when hw_sel_i is 1 |
| wr_lock_i | input | 1 | Write protect for registers A and B |
| pad_val_o | output | 5 | Logical output value |
| pad_pull_low_o | output | 5 | Per-bit pull-low enable for the open-drain pads |

## Verification
A corrupted register shows up at the ports as soon as the register is read back, and also on pad_val_o in the same cycle whenever that register is the active source. This is why every stimulus vector reloads both registers and then checks the pads. A snapshot captured on the wrong edge shows up only when address 2 is read. The bench therefore changes in_port_i between the strobe edge and the capture edge, and again after the capture edge. A write-lock or address-decode fault stays hidden until a later readback, so each ignored write is followed at once by a read of the affected registers.

// File: rtl/osel_pkg.sv
package osel_pkg;
  localparam int DW = 8;
  localparam int PW = 5;
  localparam int AW = 8;
  localparam int NREG = 2;
  localparam int SEL_HI = 7;
  localparam int SEL_LO = 6;

  typedef enum logic [1:0] {
    SRC_A      = 2'b00,
    SRC_B      = 2'b01,
    SRC_IN     = 2'b10,
    SRC_IN_ALT = 2'b11
  } src_e;

  localparam logic [AW-1:0] ADDR_A    = AW'(0);
  localparam logic [AW-1:0] ADDR_B    = AW'(1);
  localparam logic [AW-1:0] ADDR_SNAP = AW'(2);
  localparam logic [DW-1:0] REG_RST   = DW'(8'h80);

  // data field: register bit 5 -> out[4], bits 3:0 -> out[3:0]
  function automatic logic [PW-1:0] field_of(logic [DW-1:0] r);
    return {r[5], r[3:0]};
  endfunction
endpackage

// File: rtl/osel_reg_bank.sv
module osel_reg_bank
  import osel_pkg::*;
(
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic                          wr_lock_i,
  input  logic [AW-1:0]                 addr_i,
  input  logic [DW-1:0]                 wdata_i,
  output logic [NREG-1:0][DW-1:0]       regs_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        regs_o[g] <= REG_RST;
      else if (wr_en_i && !wr_lock_i && addr_i == AW'(g))
        regs_o[g] <= wdata_i;
    end
  end
endmodule

// File: rtl/osel_snapshot.sv
module osel_snapshot
  import osel_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [PW-1:0] in_i,
  output logic [PW-1:0] snap_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      snap_o <= '0;
    end else begin
      pend_q <= start_i;
      if (pend_q) snap_o <= in_i;
    end
  end
endmodule

// File: rtl/osel_mux.sv
module osel_mux
  import osel_pkg::*;
(
  input  logic [DW-1:0] reg_a_i,
  input  logic [DW-1:0] reg_b_i,
  input  logic [PW-1:0] in_i,
  input  logic          hw_sel_i,
  input  logic          ab_sel_i,
  input  logic          out_en_i,
  output logic [PW-1:0] val_o
);
  src_e         src;
  logic [PW-1:0] pick;

  always_comb begin
    if (hw_sel_i) src = ab_sel_i ? SRC_B : SRC_A;
    else          src = src_e'(reg_a_i[SEL_HI:SEL_LO]);
    unique case (src)
      SRC_A:   pick = field_of(reg_a_i);
      SRC_B:   pick = field_of(reg_b_i);
      default: pick = in_i;
    endcase
    val_o = out_en_i ? pick : '0;
  end
endmodule

// File: rtl/reg_out_sel.sv
module reg_out_sel
  import osel_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [7:0]    addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o,
  input  logic          start_i,
  input  logic [4:0]    in_port_i,
  input  logic          out_en_i,
  input  logic          hw_sel_i,
  input  logic          ab_sel_i,
  input  logic          wr_lock_i,
  output logic [4:0]    pad_val_o,
  output logic [4:0]    pad_pull_low_o
);
  logic [NREG-1:0][DW-1:0] regs;
  logic [DW-1:0]           reg_a_q;
  logic [DW-1:0]           reg_b_q;
  logic [PW-1:0]           snap_q;

  osel_reg_bank u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (req_i & we_i),
    .wr_lock_i (wr_lock_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .regs_o    (regs)
  );

  assign reg_a_q = regs[0];
  assign reg_b_q = regs[1];

  osel_snapshot u_snap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .in_i    (in_port_i),
    .snap_o  (snap_q)
  );

  osel_mux u_mux (
    .reg_a_i  (reg_a_q),
    .reg_b_i  (reg_b_q),
    .in_i     (in_port_i),
    .hw_sel_i (hw_sel_i),
    .ab_sel_i (ab_sel_i),
    .out_en_i (out_en_i),
    .val_o    (pad_val_o)
  );

  assign pad_pull_low_o = ~pad_val_o;

  always_comb begin
    unique case (addr_i)
      ADDR_A:    rdata_o = reg_a_q;
      ADDR_B:    rdata_o = reg_b_q;
      ADDR_SNAP: rdata_o = {{(DW-PW){1'b0}}, snap_q};
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/reg_out_sel_chk.sv
module reg_out_sel_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_i,
  input logic       we_i,
  input logic [7:0] addr_i,
  input logic [7:0] rdata_o,
  input logic       start_i,
  input logic [4:0] in_port_i,
  input logic       out_en_i,
  input logic       hw_sel_i,
  input logic       ab_sel_i,
  input logic       wr_lock_i,
  input logic [4:0] pad_val_o,
  input logic [4:0] pad_pull_low_o,
  input logic [7:0] reg_a_q,
  input logic [7:0] reg_b_q,
  input logic [4:0] snap_q
);
  assert_force_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_en_i |-> pad_val_o == 5'd0);

  assert_in_route_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_en_i && !hw_sel_i && reg_a_q[7] |-> pad_val_o == in_port_i);

  assert_hw_pick_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_en_i && hw_sel_i && ab_sel_i |-> pad_val_o == {reg_b_q[5], reg_b_q[3:0]});

  assert_locked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && wr_lock_i |=> $stable(reg_a_q) && $stable(reg_b_q));

  assert_snap_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> ##1 (snap_q == $past(in_port_i)));

  assert_snap_fmt_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == 8'd2 |-> rdata_o == {3'b000, snap_q});

  assert_high_addr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && addr_i > 8'd2 |=> $stable(reg_a_q) && $stable(reg_b_q));

  assert_high_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i > 8'd2 |-> rdata_o == 8'h00);

  assert_pad_drive_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_pull_low_o & pad_val_o) == 5'd0);
endmodule

bind reg_out_sel reg_out_sel_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_i          (req_i),
  .we_i           (we_i),
  .addr_i         (addr_i),
  .rdata_o        (rdata_o),
  .start_i        (start_i),
  .in_port_i      (in_port_i),
  .out_en_i       (out_en_i),
  .hw_sel_i       (hw_sel_i),
  .ab_sel_i       (ab_sel_i),
  .wr_lock_i      (wr_lock_i),
  .pad_val_o      (pad_val_o),
  .pad_pull_low_o (pad_pull_low_o),
  .reg_a_q        (reg_a_q),
  .reg_b_q        (reg_b_q),
  .snap_q         (snap_q)
);

// File: tb/reg_out_sel_tb_top.sv
module reg_out_sel_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0, we = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata;
  logic       start = 1'b0;
  logic [4:0] in_port = '0;
  logic       out_en = 1'b1, hw_sel = 1'b0, ab_sel = 1'b0, wr_lock = 1'b0;
  logic [4:0] pad_val, pad_pl;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  reg_out_sel dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .start_i(start), .in_port_i(in_port),
    .out_en_i(out_en), .hw_sel_i(hw_sel), .ab_sel_i(ab_sel),
    .wr_lock_i(wr_lock), .pad_val_o(pad_val), .pad_pull_low_o(pad_pl)
  );

  typedef struct packed {
    logic [7:0] a;
    logic [7:0] b;
    logic       hw;
    logic       ab;
    logic       en;
    logic [4:0] inp;
    logic [4:0] exp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{8'h2A, 8'h55, 1'b0, 1'b0, 1'b1, 5'h00, 5'h1A},  // R2 R3 src A
    '{8'h55, 8'h2F, 1'b0, 1'b0, 1'b1, 5'h00, 5'h1F},  // R2 src B
    '{8'h80, 8'h00, 1'b0, 1'b0, 1'b1, 5'h0B, 5'h0B},  // R2 code 10
    '{8'hC0, 8'h00, 1'b0, 1'b0, 1'b1, 5'h14, 5'h14},  // R2 code 11
    '{8'h89, 8'h00, 1'b1, 1'b0, 1'b1, 5'h1F, 5'h09},  // R5 pin A
    '{8'h89, 8'h30, 1'b1, 1'b1, 1'b1, 5'h1F, 5'h10},  // R5 pin B
    '{8'h2A, 8'h00, 1'b0, 1'b0, 1'b0, 5'h1F, 5'h00},  // R4
    '{8'h80, 8'h3F, 1'b1, 1'b1, 1'b0, 5'h1F, 5'h00},  // R4 over R5
    '{8'h10, 8'h00, 1'b0, 1'b0, 1'b1, 5'h00, 5'h00},  // R3 bit 4 dropped
    '{8'h1F, 8'h00, 1'b0, 1'b0, 1'b1, 5'h00, 5'h0F},  // R3
    '{8'h7F, 8'h20, 1'b0, 1'b0, 1'b1, 5'h00, 5'h10},  // R3 bit 5 -> out 4
    '{8'hBF, 8'h00, 1'b0, 1'b0, 1'b1, 5'h05, 5'h05}   // R2 input
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    req = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    // R10 reset state
    in_port = 5'h13;
    #20;
    chk(pad_val == 5'h13, "R10 pads follow input", pad_val, 5'h13);
    addr = 8'd0; #1 chk(rdata == 8'h80, "R10 reg A", rdata, 8'h80);
    addr = 8'd1; #1 chk(rdata == 8'h80, "R10 reg B", rdata, 8'h80);
    addr = 8'd2; #1 chk(rdata == 8'h00, "R10 snapshot", rdata, 8'h00);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      wr(8'd0, VECS[i].a);
      wr(8'd1, VECS[i].b);
      hw_sel = VECS[i].hw; ab_sel = VECS[i].ab;
      out_en = VECS[i].en; in_port = VECS[i].inp;
      #1;
      chk(pad_val == VECS[i].exp, $sformatf("R2 R3 R4 R5 vec %0d", i), pad_val, VECS[i].exp);
      chk(pad_pl == ~VECS[i].exp, $sformatf("R11 vec %0d", i), pad_pl, ~VECS[i].exp);
    end
    hw_sel = 1'b0; out_en = 1'b1;

    // R1 readback
    wr(8'd0, 8'h3C); wr(8'd1, 8'hD7);
    rd(8'd0, d); chk(d == 8'h3C, "R1 read A", d, 8'h3C);
    rd(8'd1, d); chk(d == 8'hD7, "R1 read B", d, 8'hD7);

    // R6 write lock
    wr_lock = 1'b1;
    wr(8'd0, 8'h80); wr(8'd1, 8'h00);
    wr_lock = 1'b0;
    rd(8'd0, d); chk(d == 8'h3C, "R6 A held", d, 8'h3C);
    rd(8'd1, d); chk(d == 8'hD7, "R6 B held", d, 8'hD7);
    #1 chk(pad_val == 5'h1C, "R6 pads from held A", pad_val, 5'h1C);

    // R7 snapshot captured one edge after strobe
    @(negedge clk); start = 1'b1; in_port = 5'h0C;
    @(negedge clk); start = 1'b0; in_port = 5'h1B;
    @(negedge clk); in_port = 5'h02;
    rd(8'd2, d); chk(d == 8'h1B, "R7 capture edge", d, 8'h1B);
    repeat (3) @(negedge clk);
    rd(8'd2, d); chk(d == 8'h1B, "R7 hold", d, 8'h1B);

    // R8 snapshot write ignored
    wr(8'd2, 8'hFF);
    rd(8'd2, d); chk(d == 8'h1B, "R8 write ignored", d, 8'h1B);

    // R9 high addresses
    wr(8'd5, 8'h00); wr(8'hFF, 8'h00);
    rd(8'd0, d); chk(d == 8'h3C, "R9 A untouched", d, 8'h3C);
    rd(8'd1, d); chk(d == 8'hD7, "R9 B untouched", d, 8'hD7);
    rd(8'd5, d); chk(d == 8'h00, "R9 read zero", d, 8'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule